// File: doc/BRIEF.md
# DDS Sweep Accumulator Core

This block produces the phase word of a direct digital synthesizer whose output frequency can ramp linearly between two limits. A frequency accumulator holds an offset above a start frequency word. The offset grows by a step word each time a ramp-rate down-counter expires, and it stops growing once the sum reaches a stop frequency word. A 32-bit phase accumulator adds the resulting frequency word on every clock. A sine/cosine select flag goes out with the phase word, so a downstream phase-to-amplitude stage knows which function to apply.

Settings are staged and take effect together. A 32-bit configuration word is written into a staging register. On an update strobe, it moves into the active register along with the start, stop, step and ramp-period inputs. The same strobe can also clear either accumulator for one cycle, or restart the current ramp countdown, when the active configuration enables that action. A level bit in the configuration holds each accumulator at zero for as long as it is set. Reading the configuration returns the active word together with a sticky lock-fault flag, and the read clears that flag.

Top module: `dds_sweep_core`

## Requirements
- R1: After reset the readback word is 0, the phase word is 0, `sine_sel` is 0 and the frequency offset is 0.
- R2: A configuration write changes only the staging register. The readback shows the new value only after the next update strobe. Bits 31:25 and 17:16 always read 0 whatever was written. Bits 15:0 read back as written.
- R3: The phase word adds the current frequency word (start word plus offset) on every clock and wraps modulo 2^32.
- R4: The ramp counter is 0 after reset. When it is 0 it produces a step tick and reloads from the active ramp period P. Otherwise it counts down, so ticks come every P+1 cycles. Each tick adds the step word to the frequency offset.
- R5: When start plus offset plus step would reach or exceed the stop word, the offset becomes stop minus start. The frequency word then stays at the stop word.
- R6: With bit 23 of the active configuration set, an update strobe loads the ramp counter with the ramp-period input presented with that strobe. With bit 23 clear, the counter reloads only at a tick.
- R7: With bit 22 of the configuration active before the strobe set, an update strobe clears the frequency offset for that cycle, and the ramp resumes from the start word. With bit 22 clear, the strobe leaves the offset unchanged.
- R8: With bit 21 of the configuration active before the strobe set, an update strobe sets the phase word to 0, and accumulation continues from 0.
- R9: While active bit 19 is 1, the frequency offset is 0 and does not step.
- R10: While active bit 18 is 1, the phase word is 0.
- R11: `sine_sel` equals active bit 20: 0 selects cosine, 1 selects sine.
- R12: Readback bit 24 sets one cycle after `lock_fault` is high and stays set until a read strobe. A read clears it on the next cycle unless `lock_fault` is high in the same cycle, in which case it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesis clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the staging configuration register |
| cfg_wdata | input | 32 | Configuration word to stage |
| cfg_rd | input | 1 | Read strobe; clears the sticky lock-fault bit |
| cfg_rdata | output | 32 | Active configuration with sticky bit 24 |
| upd_strobe | input | 1 | Transfers staged and input settings; triggers enabled one-shot actions |
| start_freq | input | 32 | Start frequency word, captured on update |
| stop_freq | input | 32 | Stop frequency word, captured on update |
| step_freq | input | 32 | Frequency step word, captured on update |
| step_period | input | 16 | Ramp period, captured on update |
| lock_fault | input | 1 | Loss-of-lock indication |
| phase_word | output | 32 | Phase accumulator value |
| sine_sel | output | 1 | 1 selects sine, 0 selects cosine |

## Verification
The frequency offset and the ramp counter have no port of their own. A wrong offset or a misplaced tick shows up as a change in the per-cycle phase increment on the first clock after the fault, and it stays in the phase word from then on. A missed clear or a missed hold of the phase accumulator shows as a nonzero phase word one cycle after the strobe or level. Configuration staging errors and sticky-bit errors show directly on the readback in the cycle after the triggering strobe. The bench therefore compares every output on every clock against a behavioural model, so any divergence is caught within one cycle.

// File: rtl/dds_sweep_pkg.sv
// Package: shared configuration bit positions and the option bundle.
// Assumes a 32-bit configuration word; positions are fixed by the register layout.
package dds_sweep_pkg;
    localparam int CFG_W        = 32;
    localparam int BIT_STICKY   = 24;
    localparam int BIT_RESTART  = 23;
    localparam int BIT_F_AUTO   = 22;
    localparam int BIT_P_AUTO   = 21;
    localparam int BIT_SINE     = 20;
    localparam int BIT_F_HOLD   = 19;
    localparam int BIT_P_HOLD   = 18;
    localparam logic [CFG_W-1:0] CFG_KEEP_MASK = 32'h00FC_FFFF;

    typedef struct packed {
        logic restart_on_upd;
        logic freq_autoclr;
        logic phase_autoclr;
        logic sine;
        logic freq_hold;
        logic phase_hold;
    } cfg_opts_t;
endpackage

// File: rtl/dds_cfg_bank.sv
// Configuration bank: staging register, active register, captured sweep
// parameters and the sticky lock-fault flag. All transfers happen on upd.
// Assumes cfg_wr and upd in the same cycle move the previously staged word.
module dds_cfg_bank
    import dds_sweep_pkg::*;
#(
    parameter int FW = 32,
    parameter int PW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cfg_rd,
    input  logic             upd,
    input  logic [FW-1:0]    start_in,
    input  logic [FW-1:0]    stop_in,
    input  logic [FW-1:0]    step_in,
    input  logic [PW-1:0]    period_in,
    input  logic             lock_fault,
    output logic [CFG_W-1:0] cfg_rdata,
    output cfg_opts_t        opts,
    output logic [FW-1:0]    start_act,
    output logic [FW-1:0]    stop_act,
    output logic [FW-1:0]    step_act,
    output logic [PW-1:0]    period_act
);
    logic [CFG_W-1:0] stage_q;
    logic [CFG_W-1:0] active_q;
    logic             sticky_q;

    // Staging register: captures writes with unused bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q <= '0;
        else if (cfg_wr) stage_q <= cfg_wdata & CFG_KEEP_MASK;
    end

    // Active register and sweep parameters: loaded together on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= '0;
            start_act  <= '0;
            stop_act   <= '0;
            step_act   <= '0;
            period_act <= '0;
        end else if (upd) begin
            active_q   <= stage_q;
            start_act  <= start_in;
            stop_act   <= stop_in;
            step_act   <= step_in;
            period_act <= period_in;
        end
    end

    // Sticky flag: a new fault wins over a simultaneous read.
    always_ff @(posedge clk) begin
        if (!rst_n)          sticky_q <= 1'b0;
        else if (lock_fault) sticky_q <= 1'b1;
        else if (cfg_rd)     sticky_q <= 1'b0;
    end

    // Readback merges the sticky flag into the active word.
    always_comb begin
        cfg_rdata             = active_q;
        cfg_rdata[BIT_STICKY] = sticky_q;
    end

    // Option decode for the datapath modules.
    always_comb begin
        opts.restart_on_upd = active_q[BIT_RESTART];
        opts.freq_autoclr   = active_q[BIT_F_AUTO];
        opts.phase_autoclr  = active_q[BIT_P_AUTO];
        opts.sine           = active_q[BIT_SINE];
        opts.freq_hold      = active_q[BIT_F_HOLD];
        opts.phase_hold     = active_q[BIT_P_HOLD];
    end

    a_r12_sticky_sets: assert property (@(posedge clk) disable iff (!rst_n)
        lock_fault |=> cfg_rdata[BIT_STICKY]);
    a_r12_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && !lock_fault) |=> !cfg_rdata[BIT_STICKY]);
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[31:25] == '0) && (cfg_rdata[17:16] == '0));
    a_r2_hold_without_upd: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> (cfg_rdata[23:0] & 24'hEFFFFF) == ($past(cfg_rdata[23:0]) & 24'hEFFFFF));
endmodule

// File: rtl/dds_step_timer.sv
// Ramp-rate timer: a down-counter that ticks on zero and reloads from the
// active period, so ticks come every period+1 cycles. An optional restart
// reloads it from the period presented with the update strobe.
module dds_step_timer #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_act,
    input  logic [PW-1:0] period_new,
    input  logic          restart,
    output logic          tick
);
    logic [PW-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    // Countdown with reload at terminal count or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= period_new;
        else if (tick)    cnt_q <= period_act;
        else              cnt_q <= cnt_q - 1'b1;
    end

    a_r6_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt_q == $past(period_new));
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/dds_freq_ramp.sv
// Frequency offset accumulator: steps by step_act on each tick and saturates
// so that start+offset never passes stop. Assumes stop >= start.
module dds_freq_ramp #(
    parameter int FW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] start_act,
    input  logic [FW-1:0] stop_act,
    input  logic [FW-1:0] step_act,
    input  logic          tick,
    input  logic          hold,
    input  logic          upd,
    input  logic          autoclr_en,
    output logic [FW-1:0] freq_word
);
    localparam int SW = FW + 2;

    logic [FW-1:0] ofs_q;
    logic [SW-1:0] trial;

    // Trial sum in extended width so the saturation compare cannot wrap.
    assign trial     = SW'(start_act) + SW'(ofs_q) + SW'(step_act);
    assign freq_word = start_act + ofs_q;

    // Offset update: hold, one-shot clear, saturating step.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ofs_q <= '0;
        else if (hold)               ofs_q <= '0;
        else if (upd && autoclr_en)  ofs_q <= '0;
        else if (tick) begin
            if (trial >= SW'(stop_act)) ofs_q <= stop_act - start_act;
            else                        ofs_q <= ofs_q + step_act;
        end
    end

    a_r9_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ofs_q == '0);
    a_r7_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && autoclr_en) |=> ofs_q == '0);
    a_r4_no_step_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hold && !upd) |=> $stable(ofs_q));
endmodule

// File: rtl/dds_phase_acc.sv
// Phase accumulator: adds the frequency word every clock, modulo 2^FW,
// with static hold-at-zero and a one-shot clear on enabled update.
module dds_phase_acc #(
    parameter int FW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] freq_word,
    input  logic          hold,
    input  logic          upd,
    input  logic          autoclr_en,
    output logic [FW-1:0] phase
);
    // Accumulate, or clear on hold / enabled update.
    always_ff @(posedge clk) begin
        if (!rst_n)                 phase <= '0;
        else if (hold)              phase <= '0;
        else if (upd && autoclr_en) phase <= '0;
        else                        phase <= phase + freq_word;
    end

    a_r10_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> phase == '0);
    a_r8_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && autoclr_en && !hold) |=> phase == '0);
endmodule

// File: rtl/dds_sweep_core.sv
// Top: DDS linear sweep accumulator pair. Wires the configuration bank,
// ramp timer, frequency offset accumulator and phase accumulator.
// One-shot actions use the configuration active before the update strobe.
module dds_sweep_core
    import dds_sweep_pkg::*;
#(
    parameter int FW = 32,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [31:0]   cfg_wdata,
    input  logic          cfg_rd,
    output logic [31:0]   cfg_rdata,
    input  logic          upd_strobe,
    input  logic [FW-1:0] start_freq,
    input  logic [FW-1:0] stop_freq,
    input  logic [FW-1:0] step_freq,
    input  logic [PW-1:0] step_period,
    input  logic          lock_fault,
    output logic [FW-1:0] phase_word,
    output logic          sine_sel
);
    cfg_opts_t     opts;
    logic [FW-1:0] start_act, stop_act, step_act, freq_word;
    logic [PW-1:0] period_act;
    logic          tick;

    dds_cfg_bank #(.FW(FW), .PW(PW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rd(cfg_rd), .upd(upd_strobe), .start_in(start_freq),
        .stop_in(stop_freq), .step_in(step_freq), .period_in(step_period),
        .lock_fault(lock_fault), .cfg_rdata(cfg_rdata), .opts(opts),
        .start_act(start_act), .stop_act(stop_act), .step_act(step_act),
        .period_act(period_act)
    );

    dds_step_timer #(.PW(PW)) u_timer (
        .clk(clk), .rst_n(rst_n), .period_act(period_act),
        .period_new(step_period),
        .restart(upd_strobe && opts.restart_on_upd), .tick(tick)
    );

    dds_freq_ramp #(.FW(FW)) u_freq (
        .clk(clk), .rst_n(rst_n), .start_act(start_act), .stop_act(stop_act),
        .step_act(step_act), .tick(tick), .hold(opts.freq_hold),
        .upd(upd_strobe), .autoclr_en(opts.freq_autoclr), .freq_word(freq_word)
    );

    dds_phase_acc #(.FW(FW)) u_phase (
        .clk(clk), .rst_n(rst_n), .freq_word(freq_word),
        .hold(opts.phase_hold), .upd(upd_strobe),
        .autoclr_en(opts.phase_autoclr), .phase(phase_word)
    );

    assign sine_sel = opts.sine;

    a_r11_sine_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sine_sel == cfg_rdata[BIT_SINE]);
endmodule

// File: tb/dds_sweep_core_tb.sv
module dds_sweep_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0, upd_strobe = 1'b0, lock_fault = 1'b0;
    logic [31:0] cfg_wdata = '0, start_freq = '0, stop_freq = '0, step_freq = '0;
    logic [15:0] step_period = '0;
    logic [31:0] cfg_rdata, phase_word;
    logic        sine_sel;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    dds_sweep_core u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata), .upd_strobe(upd_strobe),
        .start_freq(start_freq), .stop_freq(stop_freq), .step_freq(step_freq),
        .step_period(step_period), .lock_fault(lock_fault),
        .phase_word(phase_word), .sine_sel(sine_sel)
    );

    // Behavioural reference model, advanced on each rising edge.
    longint m_stage, m_act, m_start, m_stop, m_step, m_per, m_ofs, m_cnt, m_phase;
    bit     m_sticky;

    always @(posedge clk) begin
        longint fw, n_ofs, n_cnt, n_phase;
        bit tk;
        if (!rst_n) begin
            m_stage = 0; m_act = 0; m_start = 0; m_stop = 0; m_step = 0;
            m_per = 0; m_ofs = 0; m_cnt = 0; m_phase = 0; m_sticky = 0;
        end else begin
            fw = (m_start + m_ofs) % 64'h1_0000_0000;
            tk = (m_cnt == 0);
            if (m_act[18]) n_phase = 0;
            else if (upd_strobe && m_act[21]) n_phase = 0;
            else n_phase = (m_phase + fw) % 64'h1_0000_0000;
            if (m_act[19]) n_ofs = 0;
            else if (upd_strobe && m_act[22]) n_ofs = 0;
            else if (tk) n_ofs = (m_start + m_ofs + m_step >= m_stop) ? m_stop - m_start : m_ofs + m_step;
            else n_ofs = m_ofs;
            if (upd_strobe && m_act[23]) n_cnt = step_period;
            else if (tk) n_cnt = m_per;
            else n_cnt = m_cnt - 1;
            if (lock_fault) m_sticky = 1;
            else if (cfg_rd) m_sticky = 0;
            if (upd_strobe) begin
                m_act = m_stage; m_start = start_freq; m_stop = stop_freq;
                m_step = step_freq; m_per = step_period;
            end
            if (cfg_wr) m_stage = cfg_wdata & 32'h00FC_FFFF;
            m_phase = n_phase; m_ofs = n_ofs; m_cnt = n_cnt;
        end
    end

    task automatic chk(input longint act, input longint exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison, mid-cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            longint er;
            er = m_act | (longint'(m_sticky) << 24);
            chk(phase_word, m_phase, cur_req, "phase_word");
            chk(cfg_rdata, er, cur_req, "cfg_rdata");
            chk(sine_sel, m_act[20], cur_req, "sine_sel");
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr_cfg(input logic [31:0] v);
        cfg_wr = 1'b1; cfg_wdata = v; cyc(); cfg_wr = 1'b0;
    endtask

    task automatic pulse_upd();
        upd_strobe = 1'b1; cyc(); upd_strobe = 1'b0;
    endtask

    task automatic set_sweep(input logic [31:0] s, input logic [31:0] e,
                             input logic [31:0] d, input logic [15:0] p);
        start_freq = s; stop_freq = e; step_freq = d; step_period = p;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R1: reset state
        chk(cfg_rdata, 0, "R1", "reset readback");
        chk(phase_word, 0, "R1", "reset phase");
        chk(sine_sel, 0, "R1", "reset sine_sel");
        cyc(3);

        // R2: staging and unused bits
        cur_req = "R2";
        wr_cfg(32'hFFFF_FFFF);
        cyc(2);
        chk(cfg_rdata, 0, "R2", "staged not yet active");
        pulse_upd();
        chk(cfg_rdata, 32'h00FC_FFFF, "R2", "active after update");
        wr_cfg(32'h0000_0000);
        pulse_upd();
        chk(cfg_rdata, 0, "R2", "cleared after update");

        // R3: phase accumulation and wrap
        cur_req = "R3";
        set_sweep(32'h1000_0000, 32'h1000_0000, 0, 0);
        pulse_upd();
        cyc(40);

        // R4: stepping with period 3
        cur_req = "R4";
        wr_cfg(32'h0040_0000);             // stage freq auto-clear (R7)
        set_sweep(100, 10000, 7, 3);
        pulse_upd();
        pulse_upd();                       // clears offset: ramp from start
        chk(phase_word != 0, 1, "R4", "phase running");
        cyc(60);

        // R5: saturation at stop word
        cur_req = "R5";
        set_sweep(100, 130, 7, 1);
        pulse_upd();
        cyc(40);

        // R6: restart on update
        cur_req = "R6";
        wr_cfg(32'h0080_0000);
        set_sweep(50, 100000, 3, 9);
        pulse_upd();
        cyc(4);
        pulse_upd();
        cyc(3);
        step_period = 5;
        pulse_upd();
        cyc(30);
        wr_cfg(32'h0000_0000);
        pulse_upd();
        cyc(4);
        pulse_upd();                       // no restart: reload only at tick
        cyc(20);

        // R7: frequency auto-clear enabled and disabled
        cur_req = "R7";
        wr_cfg(32'h0040_0000);
        set_sweep(10, 5000, 11, 2);
        pulse_upd();
        cyc(25);
        pulse_upd();
        cyc(10);
        wr_cfg(32'h0000_0000);
        pulse_upd();
        cyc(10);
        pulse_upd();                       // offset must persist
        cyc(10);

        // R8: phase auto-clear
        cur_req = "R8";
        wr_cfg(32'h0020_0000);
        pulse_upd();
        cyc(5);
        pulse_upd();
        chk(phase_word, 0, "R8", "phase cleared by strobe");
        cyc(10);

        // R9: frequency hold
        cur_req = "R9";
        wr_cfg(32'h0008_0000);
        pulse_upd();
        cyc(20);
        wr_cfg(32'h0000_0000);
        pulse_upd();
        cyc(20);

        // R10: phase hold
        cur_req = "R10";
        wr_cfg(32'h0004_0000);
        pulse_upd();
        cyc(2);
        chk(phase_word, 0, "R10", "phase held");
        cyc(5);
        wr_cfg(32'h0000_0000);
        pulse_upd();
        cyc(10);

        // R11: sine select
        cur_req = "R11";
        wr_cfg(32'h0010_0000);
        pulse_upd();
        chk(sine_sel, 1, "R11", "sine selected");
        wr_cfg(32'h0000_0000);
        pulse_upd();
        chk(sine_sel, 0, "R11", "cosine selected");

        // R12: sticky lock fault
        cur_req = "R12";
        lock_fault = 1'b1; cyc(); lock_fault = 1'b0;
        cyc(5);
        chk(cfg_rdata[24], 1, "R12", "sticky after relock");
        cfg_rd = 1'b1; cyc(); cfg_rd = 1'b0;
        chk(cfg_rdata[24], 0, "R12", "cleared by read");
        lock_fault = 1'b1; cfg_rd = 1'b1; cyc();
        lock_fault = 1'b0; cfg_rd = 1'b0;
        chk(cfg_rdata[24], 1, "R12", "fault wins over read");
        cyc(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule